// File: doc/BRIEF.md
# Dual-Channel Capture Edge Selector

This block sits in front of a 16-bit timer's capture logic. Two asynchronous capture pins are brought into the clock domain. Each pin is compared against an edge condition that software programs. When the condition is met and the timer runs in a mode that permits capture, the block pulses a strobe for that channel for one cycle. On the same clock edge it copies the running count into that channel's capture register.

Software reaches the edge settings through an 8-bit control register. The register takes whole-byte writes and single-bit writes. Address decoding is done outside, and the register sits at offset 3 of the timer's space. The edge settings are frozen while the timer's count enable is set. A write that tries to change them during that time is dropped, and a sticky error flag records it. The counter, the mode decoder and the interrupt logic all live outside the block and reach it only as ports.

Top module: `capsel_front`

## Requirements
- R1: After reset, ctl_rd is 0x00, cap_stb is 0, both capture registers are 0 and wr_err is 0.
- R2: ctl_rd[7:4] always reads 0. ctl_rd[3:2] is the channel 1 edge code and ctl_rd[1:0] is the channel 0 edge code. A byte write loads wr_data[3:0] into bits 3:0.
- R3: A single-bit write with bit_idx 0 to 3 sets that one bit to bit_val and leaves the others unchanged. A single-bit write with bit_idx 4 to 7 has no effect. When byte_we and bit_we are both high, the byte write wins.
- R4: The edge codes are: 00 captures on no edge, 01 on a rising edge, 10 on a falling edge, and 11 on either edge.
- R5: A valid edge raises a strobe only while mode equals MODE_FREE (default 1) or MODE_PWM (default 5). With any other mode there is no strobe and no capture.
- R6: A pin change first sampled at clock edge k raises cap_stb for that channel after edge k+2. The strobe lasts one cycle, and cap_stb stays low after edges k and k+1.
- R7: On the edge that raises a channel's strobe, that channel's capture register loads the count_val present at that edge. At all other times it holds its value.
- R8: While count_en is 1, a write that would change bits 3:0 is ignored. A write of the current value is accepted.
- R9: A write ignored under R8 sets wr_err. wr_err then stays set while count_en is 1 and clears on the first edge at which count_en is 0.
- R10: Both channels can capture in the same cycle. Each channel updates only its own strobe and capture register, and neither takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_we | input | 1 | Whole-register write strobe |
| wr_data | input | 8 | Write data for byte writes |
| bit_we | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| ctl_rd | output | 8 | Control register read value |
| count_en | input | 1 | Timer count enable |
| mode | input | 3 | Decoded timer mode |
| cap_pin | input | 2 | Asynchronous capture inputs, bit n is channel n |
| count_val | input | 16 | Running counter value |
| cap_stb | output | 2 | One-cycle capture strobes, bit n is channel n |
| cap0_val | output | 16 | Channel 0 capture register |
| cap1_val | output | 16 | Channel 1 capture register |
| wr_err | output | 1 | Sticky error flag for blocked writes |

## Verification
The assertions take mode and count_val to be synchronous to clk. They compare a strobe against the values these inputs held one edge earlier, which needs both inputs to be stable around each edge. The bench changes every input on the falling clock edge and holds count_val and mode constant for the whole window in which a capture can occur. It changes a capture pin only after that pin has been stable for several cycles, so each edge it checks travels through the synchroniser on its own.

// File: rtl/capsel_front.sv
module capsel_front #(
  parameter int CNT_W = 16,
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_FREE = 3'd1,
  parameter logic [MODE_W-1:0] MODE_PWM = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [7:0]        wr_data,
  input  logic              bit_we,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  output logic [7:0]        ctl_rd,
  input  logic              count_en,
  input  logic [MODE_W-1:0] mode,
  input  logic [1:0]        cap_pin,
  input  logic [CNT_W-1:0]  count_val,
  output logic [1:0]        cap_stb,
  output logic [CNT_W-1:0]  cap0_val,
  output logic [CNT_W-1:0]  cap1_val,
  output logic              wr_err
);

  logic [3:0] sel_q, sel_nxt;
  logic       req, blocked;
  logic [1:0] sy1, sy2, sy3;
  logic [1:0] rise, fall, hit;
  logic       mode_ok;
  logic [CNT_W-1:0] cap_q [2];

  always_comb begin
    sel_nxt = sel_q;
    req = 1'b0;
    if (byte_we) begin
      sel_nxt = wr_data[3:0];
      req = 1'b1;
    end else if (bit_we && !bit_idx[2]) begin
      sel_nxt[bit_idx[1:0]] = bit_val;
      req = 1'b1;
    end
  end

  assign blocked = req && count_en && (sel_nxt != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      if (req && !blocked) sel_q <= sel_nxt;
      if (!count_en)       wr_err <= 1'b0;
      else if (blocked)    wr_err <= 1'b1;
    end
  end

  assign ctl_rd  = {4'b0000, sel_q};
  assign mode_ok = (mode == MODE_FREE) || (mode == MODE_PWM);
  assign rise    = sy2 & ~sy3;
  assign fall    = ~sy2 & sy3;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign hit[c] = (sel_q[2*c] & rise[c]) | (sel_q[2*c+1] & fall[c]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_stb[c] <= 1'b0;
        cap_q[c]   <= '0;
      end else begin
        cap_stb[c] <= hit[c] & mode_ok;
        if (hit[c] && mode_ok) cap_q[c] <= count_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= cap_pin;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  assign cap0_val = cap_q[0];
  assign cap1_val = cap_q[1];

endmodule

// File: rtl/capsel_front_chk.sv
module capsel_front_chk #(
  parameter int CNT_W = 16,
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] MODE_FREE = 3'd1,
  parameter logic [MODE_W-1:0] MODE_PWM = 3'd5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctl_rd,
  input logic              count_en,
  input logic [MODE_W-1:0] mode,
  input logic [CNT_W-1:0]  count_val,
  input logic [1:0]        cap_stb,
  input logic [CNT_W-1:0]  cap0_val,
  input logic [CNT_W-1:0]  cap1_val,
  input logic              wr_err
);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[7:4] == 4'b0000);

  a_r5_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb != 2'b00) |-> ($past(mode) == MODE_FREE || $past(mode) == MODE_PWM));

  a_r7_cap0_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb[0] |-> cap0_val == $past(count_val));

  a_r10_cap1_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb[1] |-> cap1_val == $past(count_val));

  a_r7_cap0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb[0] |-> $stable(cap0_val) || $past(!rst_n));

  a_r4_ch0_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[1:0] == 2'b00) |=> !cap_stb[0]);

  a_r4_ch1_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd[3:2] == 2'b00) |=> !cap_stb[1]);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> $stable(ctl_rd));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && count_en) |=> wr_err);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> !wr_err);

endmodule

bind capsel_front capsel_front_chk #(
  .CNT_W(CNT_W), .MODE_W(MODE_W), .MODE_FREE(MODE_FREE), .MODE_PWM(MODE_PWM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rd(ctl_rd), .count_en(count_en), .mode(mode),
  .count_val(count_val), .cap_stb(cap_stb), .cap0_val(cap0_val),
  .cap1_val(cap1_val), .wr_err(wr_err)
);

// File: tb/sim_capsel_front.sv
module sim_capsel_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_we = 1'b0, bit_we = 1'b0, bit_val = 1'b0, count_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] bit_idx = '0;
  logic [2:0] mode = 3'd1;
  logic [1:0] cap_pin = '0;
  logic [15:0] count_val = '0;
  logic [7:0] ctl_rd;
  logic [1:0] cap_stb;
  logic [15:0] cap0_val, cap1_val;
  logic wr_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  capsel_front u0 (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .wr_data(wr_data),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val), .ctl_rd(ctl_rd),
    .count_en(count_en), .mode(mode), .cap_pin(cap_pin), .count_val(count_val),
    .cap_stb(cap_stb), .cap0_val(cap0_val), .cap1_val(cap1_val), .wr_err(wr_err)
  );

  // {ch, code[1:0], rising, msel[1:0], expect}; msel 0 free, 1 pwm, 2 other
  localparam logic [6:0] VEC [15] = '{
    7'b0_00_1_00_0, 7'b0_01_1_00_1, 7'b0_01_0_00_0, 7'b0_10_0_00_1,
    7'b0_10_1_00_0, 7'b0_11_1_00_1, 7'b0_11_0_00_1, 7'b1_00_0_00_0,
    7'b1_01_1_00_1, 7'b1_10_0_00_1, 7'b1_11_0_00_1, 7'b1_10_1_00_0,
    7'b0_11_1_10_0, 7'b1_01_1_10_0, 7'b0_01_1_01_1
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wbyte(input logic [7:0] d);
    @(negedge clk); byte_we = 1'b1; wr_data = d;
    @(negedge clk); byte_we = 1'b0;
  endtask

  task automatic wbit(input logic [2:0] i, input logic v);
    @(negedge clk); bit_we = 1'b1; bit_idx = i; bit_val = v;
    @(negedge clk); bit_we = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rd == 8'h00 && cap_stb == 2'b00 && wr_err == 1'b0, "R1 reset ctl/stb/err",
        {ctl_rd, 6'd0, cap_stb, 7'd0, wr_err}, 0);
    chk(cap0_val == 0 && cap1_val == 0, "R1 reset capture regs", {cap1_val, cap0_val}, 0);

    wbyte(8'hFF);
    chk(ctl_rd == 8'h0F, "R2 upper bits read zero", ctl_rd, 8'h0F);
    wbit(3'd1, 1'b0);
    chk(ctl_rd == 8'h0D, "R3 single bit clear", ctl_rd, 8'h0D);
    wbit(3'd6, 1'b1);
    chk(ctl_rd == 8'h0D, "R3 bit index 6 ignored", ctl_rd, 8'h0D);
    @(negedge clk); byte_we = 1'b1; wr_data = 8'h03; bit_we = 1'b1; bit_idx = 3'd3; bit_val = 1'b1;
    @(negedge clk); byte_we = 1'b0; bit_we = 1'b0;
    chk(ctl_rd == 8'h03, "R3 byte write wins", ctl_rd, 8'h03);

    count_en = 1'b1;
    wbyte(8'h05);
    chk(ctl_rd == 8'h03, "R8 blocked byte write", ctl_rd, 8'h03);
    chk(wr_err == 1'b1, "R9 error set", wr_err, 1);
    repeat (2) @(negedge clk);
    chk(wr_err == 1'b1, "R9 error sticky", wr_err, 1);
    count_en = 1'b0;
    @(negedge clk);
    chk(wr_err == 1'b0, "R9 error cleared", wr_err, 0);
    count_en = 1'b1;
    wbyte(8'h03);
    chk(ctl_rd == 8'h03 && wr_err == 1'b0, "R8 equal write accepted", {ctl_rd, 7'd0, wr_err}, 32'h300);
    wbit(3'd2, 1'b1);
    chk(ctl_rd == 8'h03 && wr_err == 1'b1, "R8 blocked bit write", {ctl_rd, 7'd0, wr_err}, 32'h301);
    count_en = 1'b0;
    @(negedge clk);

    wbyte(8'h05);
    count_val = 16'hBEEF;
    @(negedge clk); cap_pin = 2'b11;
    @(posedge clk); @(posedge clk); #1;
    chk(cap_stb == 2'b00, "R6 no strobe before edge k+2", cap_stb, 0);
    @(posedge clk); #1;
    chk(cap_stb == 2'b11, "R10 both strobes together", cap_stb, 3);
    chk(cap0_val == 16'hBEEF && cap1_val == 16'hBEEF, "R10 both captures", {cap1_val, cap0_val}, 32'hBEEFBEEF);
    @(posedge clk); #1;
    chk(cap_stb == 2'b00, "R6 strobe lasts one cycle", cap_stb, 0);

    for (int i = 0; i < 15; i++) begin
      logic ch, rising, ex;
      logic [1:0] code, ms;
      logic [15:0] capv;
      {ch, code, rising, ms, ex} = VEC[i];
      wbyte(8'h00);
      @(negedge clk); cap_pin[ch] = ~rising;
      repeat (4) @(negedge clk);
      wbyte(ch ? {4'h0, code, 2'b00} : {6'h00, code});
      mode = (ms == 2'd0) ? 3'd1 : (ms == 2'd1) ? 3'd5 : 3'd2;
      count_val = 16'h1000 + 16'(i);
      @(negedge clk); cap_pin[ch] = rising;
      @(posedge clk); @(posedge clk); #1;
      chk(cap_stb == 2'b00, "R6 vector early strobe", cap_stb, 0);
      @(posedge clk); #1;
      capv = ch ? cap1_val : cap0_val;
      chk(cap_stb[ch] == ex && cap_stb[~ch] == 1'b0, ms == 2'd2 ? "R5 mode gating" : "R4 edge code",
          cap_stb, {30'd0, ch ? ex : 1'b0, ch ? 1'b0 : ex});
      if (ex) chk(capv == 16'h1000 + 16'(i), "R7 capture value", capv, 16'h1000 + 16'(i));
      mode = 3'd1;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule